// File: doc/BRIEF.md
# Clock Divisor Transition Sequencer

This block moves the core clock divisor from one setting to another without upsetting the memory controller. It holds the divisor select and a memory control word. The memory control word carries a self-refresh enable and a refresh interval count. A requester asks for a new divisor index with a one-cycle request. The block then works out the legal path through the divisor graph. Moves between /1 and any divisor above /2 are split into two legs that pass through /2.

Each leg applies its register writes in an order that depends on its direction. After every divisor write the block waits for the clock generator to settle. When the core slows down from /1 while self-refresh is still off, it also waits for the old and new refresh intervals to drain. While a sequence runs the block reports busy, and it gives a one-cycle acknowledge when the last write has taken effect. The clock generator and the memory are outside the block; they appear only as register values and timed waits.

Top module: `clkdiv_step_seq`

## Requirements
- R1: After reset the divisor select is /1 (code 000), self-refresh enable is 0, the refresh count holds the /1 value, and busy, acknowledge and error are low.
- R2: Divisor index 0..4 selects divisors 1, 2, 4, 6, 8, driven on `div_sel` as codes 000, 001, 011, 010, 100 respectively; no other code ever appears.
- R3: The refresh count, in `mem_ctrl[14:8]`, is written as floor(CLK_HZ × 7800 / (64 × divisor × 10^9)) for the divisor being entered; `mem_ctrl[16]` is the self-refresh enable and all other `mem_ctrl` bits are 0.
- R4: A /2 to /1 leg clears self-refresh, then writes the divisor, then writes the refresh count.
- R5: A /1 to /2 leg writes the refresh count, then writes the divisor, then sets self-refresh.
- R6: A move from /1 to /4, /6 or /8, or from one of those to /1, runs as a leg to /2 followed by a leg from /2 to the target.
- R7: Any other leg to a larger divisor writes the refresh count before the divisor; any other leg to a smaller divisor writes the divisor before the refresh count.
- R8: After a divisor write, no further register change occurs for at least PLL_LOCK_CYC (16) cycles.
- R9: On the /1 to /2 leg, with self-refresh off, the divisor write follows the refresh count write by at least 64 × (old count + new count) × old divisor cycles.
- R10: A request for the divisor already selected gives an acknowledge on the next cycle, leaves every register unchanged and does not raise busy.
- R11: A request with index above 4 gives a one-cycle error pulse instead of an acknowledge and changes no register.
- R12: While a sequence runs, busy is high and requests are ignored; busy falls in the same cycle as a one-cycle acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_idx | input | 3 | Target divisor index |
| req_ack | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | One-cycle pulse for an illegal index |
| busy | output | 1 | High while a sequence runs |
| div_sel | output | 3 | Encoded divisor select |
| mem_ctrl | output | 17 | Memory control word: bit 16 self-refresh, bits 14:8 refresh count |

## Verification
Every register write is visible on `div_sel` or `mem_ctrl` at the edge where it happens. A wrong step index, a wrong leg target or a skipped hop therefore shows up at the very next write, as a value or an order the scoreboard did not expect. A wrong wait length shows up as a gap between two port changes that is too short. A stuck state shows up as an acknowledge that comes late, arrives twice or never arrives. Since the self-refresh bit must match whether the divisor is /1 whenever the block is idle, a leg that stops early breaks that pairing as soon as busy falls.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int NUM_DIV  = 5;
  localparam int IDX_W    = 3;
  localparam int CODE_W   = 3;
  localparam int CNT_W    = 7;
  localparam int MC_W     = 17;
  localparam int CNT_LSB  = 8;
  localparam int SR_BIT   = 16;

  typedef enum logic [2:0] {
    OP_NONE, OP_SR_CLR, OP_SR_SET, OP_DIV, OP_REFR
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT} st_e;

  function automatic logic [CODE_W-1:0] idx_to_code(input logic [IDX_W-1:0] i);
    case (i)
      3'd0:    return 3'b000;
      3'd1:    return 3'b001;
      3'd2:    return 3'b011;
      3'd3:    return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic int unsigned idx_to_div(input logic [IDX_W-1:0] i);
    case (i)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      default: return 8;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] refr_count(input longint unsigned hz,
                                                  input int unsigned div);
    longint unsigned v;
    v = (hz * 64'd7800) / (64'd64 * longint'(div) * 64'd1_000_000_000);
    return v[CNT_W-1:0];
  endfunction

  // Intermediate hop: /1 <-> divisors above /2 always pass through /2.
  function automatic logic [IDX_W-1:0] next_hop(input logic [IDX_W-1:0] cur,
                                                input logic [IDX_W-1:0] fin);
    if ((cur == 3'd0 && fin > 3'd1) || (cur > 3'd1 && fin == 3'd0))
      return 3'd1;
    return fin;
  endfunction
endpackage

// File: rtl/clkdiv_refr_table.sv
module clkdiv_refr_table
  import clkdiv_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 64'd400_000_000
) (
  input  logic [IDX_W-1:0] idx,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] tbl [NUM_DIV];

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_ent
    localparam logic [CNT_W-1:0] VAL = refr_count(CLK_HZ, idx_to_div(IDX_W'(g)));
    assign tbl[g] = VAL;
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NUM_DIV; i++)
      if (idx == IDX_W'(i)) cnt = tbl[i];
  end
endmodule

// File: rtl/clkdiv_leg_plan.sv
module clkdiv_leg_plan
  import clkdiv_pkg::*;
(
  input  logic [IDX_W-1:0] from_idx,
  input  logic [IDX_W-1:0] to_idx,
  input  logic [1:0]       step,
  output op_e              op,
  output logic             last,
  output logic             slow
);
  op_e        ops [3];
  logic [1:0] n_ops;

  always_comb begin
    ops[0] = OP_NONE;
    ops[1] = OP_NONE;
    ops[2] = OP_NONE;
    n_ops  = 2'd2;
    slow   = 1'b0;
    if (from_idx == 3'd1 && to_idx == 3'd0) begin
      ops[0] = OP_SR_CLR; ops[1] = OP_DIV; ops[2] = OP_REFR; n_ops = 2'd3;
    end else if (from_idx == 3'd0 && to_idx == 3'd1) begin
      ops[0] = OP_REFR; ops[1] = OP_DIV; ops[2] = OP_SR_SET; n_ops = 2'd3;
      slow   = 1'b1;
    end else if (from_idx < to_idx) begin
      ops[0] = OP_REFR; ops[1] = OP_DIV;
    end else begin
      ops[0] = OP_DIV; ops[1] = OP_REFR;
      slow   = 1'b1;
    end
    op   = (step < 2'd3) ? ops[step] : OP_NONE;
    last = (step == n_ops - 2'd1);
  end
endmodule

// File: rtl/clkdiv_wait_timer.sv
module clkdiv_wait_timer #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == W'(1));
endmodule

// File: rtl/clkdiv_step_seq.sv
module clkdiv_step_seq
  import clkdiv_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 64'd400_000_000,
  parameter int PLL_LOCK_CYC        = 16,
  parameter int DRAIN_MARGIN        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  output logic              req_ack,
  output logic              req_err,
  output logic              busy,
  output logic [CODE_W-1:0] div_sel,
  output logic [MC_W-1:0]   mem_ctrl
);
  localparam int MAX_DRAIN = 64 * 2 * ((1 << CNT_W) - 1) * 8;
  localparam int WAIT_W    = $clog2(MAX_DRAIN + DRAIN_MARGIN + PLL_LOCK_CYC + 1);
  localparam logic [CNT_W-1:0] RST_CNT = refr_count(CLK_HZ, 1);

  st_e              state_q, state_d;
  logic [IDX_W-1:0] div_q, div_d, from_q, from_d, tgt_q, tgt_d, fin_q, fin_d;
  logic [1:0]       step_q, step_d;
  logic             sr_q, sr_d, ack_q, ack_d, err_q, err_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, new_cnt;
  op_e              cur_op;
  logic             last_step, slow_leg, tmr_load, tmr_exp, adv;
  logic [WAIT_W-1:0] tmr_val, drain_len;

  clkdiv_refr_table #(.CLK_HZ(CLK_HZ)) u_tbl (.idx(tgt_q), .cnt(new_cnt));

  clkdiv_leg_plan u_plan (
    .from_idx(from_q), .to_idx(tgt_q), .step(step_q),
    .op(cur_op), .last(last_step), .slow(slow_leg)
  );

  clkdiv_wait_timer #(.W(WAIT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  assign drain_len = (WAIT_W'(cnt_q) + WAIT_W'(new_cnt)) * WAIT_W'(64)
                   * WAIT_W'(idx_to_div(from_q)) + WAIT_W'(DRAIN_MARGIN);

  always_comb begin
    state_d  = state_q;
    div_d    = div_q;
    from_d   = from_q;
    tgt_d    = tgt_q;
    fin_d    = fin_q;
    step_d   = step_q;
    sr_d     = sr_q;
    cnt_d    = cnt_q;
    ack_d    = 1'b0;
    err_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = WAIT_W'(PLL_LOCK_CYC);
    adv      = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        if (req_idx >= IDX_W'(NUM_DIV)) begin
          err_d = 1'b1;
        end else if (req_idx == div_q) begin
          ack_d = 1'b1;
        end else begin
          fin_d   = req_idx;
          from_d  = div_q;
          tgt_d   = next_hop(div_q, req_idx);
          step_d  = 2'd0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: case (cur_op)
        OP_SR_CLR: begin sr_d = 1'b0; adv = 1'b1; end
        OP_SR_SET: begin sr_d = 1'b1; adv = 1'b1; end
        OP_DIV: begin
          div_d    = tgt_q;
          tmr_load = 1'b1;
          state_d  = ST_WAIT;
        end
        OP_REFR: begin
          cnt_d = new_cnt;
          if (slow_leg && !sr_q) begin
            tmr_load = 1'b1;
            tmr_val  = drain_len;
            state_d  = ST_WAIT;
          end else begin
            adv = 1'b1;
          end
        end
        default: adv = 1'b1;
      endcase
      ST_WAIT: adv = tmr_exp;
      default: state_d = ST_IDLE;
    endcase
    if (adv) begin
      if (!last_step) begin
        step_d  = step_q + 2'd1;
        state_d = ST_RUN;
      end else if (tgt_q == fin_q) begin
        ack_d   = 1'b1;
        state_d = ST_IDLE;
      end else begin
        from_d  = tgt_q;
        tgt_d   = fin_q;
        step_d  = 2'd0;
        state_d = ST_RUN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      div_q   <= '0;
      from_q  <= '0;
      tgt_q   <= '0;
      fin_q   <= '0;
      step_q  <= '0;
      sr_q    <= 1'b0;
      cnt_q   <= RST_CNT;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      div_q   <= div_d;
      from_q  <= from_d;
      tgt_q   <= tgt_d;
      fin_q   <= fin_d;
      step_q  <= step_d;
      sr_q    <= sr_d;
      cnt_q   <= cnt_d;
      ack_q   <= ack_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    mem_ctrl                    = '0;
    mem_ctrl[SR_BIT]            = sr_q;
    mem_ctrl[CNT_LSB +: CNT_W]  = cnt_q;
  end

  assign div_sel = idx_to_code(div_q);
  assign busy    = (state_q != ST_IDLE);
  assign req_ack = ack_q;
  assign req_err = err_q;
endmodule

// File: rtl/clkdiv_step_seq_chk.sv
module clkdiv_step_seq_chk
  import clkdiv_pkg::*;
#(
  parameter int PLL_LOCK_CYC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ack,
  input logic              req_err,
  input logic              busy,
  input logic [CODE_W-1:0] div_sel,
  input logic [MC_W-1:0]   mem_ctrl
);
  logic [CODE_W-1:0] div_prev;
  logic [MC_W-1:0]   mc_prev;
  logic              primed;
  logic [15:0]       since_div;

  always_ff @(posedge clk) begin
    div_prev <= div_sel;
    mc_prev  <= mem_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      since_div <= 16'hFFFF;
    end else begin
      primed <= 1'b1;
      if (primed && div_sel != div_prev) since_div <= '0;
      else if (since_div != 16'hFFFF)    since_div <= since_div + 16'd1;
    end
  end

  AST_DIV_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    div_sel inside {3'b000, 3'b001, 3'b011, 3'b010, 3'b100});  // R2

  AST_PLL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && mem_ctrl != mc_prev) |-> (since_div >= 16'(PLL_LOCK_CYC)));  // R8

  AST_NO_JOINT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> !(mem_ctrl != mc_prev && div_sel != div_prev));  // R7

  AST_SR_PAIRS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ctrl[SR_BIT] == (div_sel != 3'b000)));  // R5

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);  // R12

  AST_BUSY_ENDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> req_ack);  // R12

  AST_ERR_NOT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_err && (req_ack || busy)));  // R11
endmodule

bind clkdiv_step_seq clkdiv_step_seq_chk #(.PLL_LOCK_CYC(PLL_LOCK_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .req_err(req_err),
  .busy(busy), .div_sel(div_sel), .mem_ctrl(mem_ctrl)
);

// File: tb/tb_clkdiv_step_seq.sv
`timescale 1ns/1ps
module tb_clkdiv_step_seq;
  localparam longint unsigned HZ = 64'd400_000_000;
  localparam int PLL = 16;

  typedef struct {
    int    kind;   // 0 self-refresh bit, 1 divisor code, 2 refresh count
    int    val;
    int    min_gap;
    string tag;
  } ev_t;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [2:0] req_idx = 3'd0;
  logic req_ack, req_err, busy;
  logic [2:0] div_sel;
  logic [16:0] mem_ctrl;

  int checks = 0, fails = 0, cyc = 0, last_ev = 0, cur = 0;
  bit mon_on = 0, done = 0, prev_div = 0;
  ev_t exp_q[$];
  logic [2:0] p_div;
  logic p_sr;
  logic [6:0] p_cnt;

  always #2.5 clk = ~clk;

  clkdiv_step_seq #(.CLK_HZ(HZ), .PLL_LOCK_CYC(PLL), .DRAIN_MARGIN(8)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .req_ack(req_ack), .req_err(req_err), .busy(busy),
    .div_sel(div_sel), .mem_ctrl(mem_ctrl)
  );

  function automatic int code_of(int i);
    case (i) 0: return 0; 1: return 1; 2: return 3; 3: return 2; default: return 4; endcase
  endfunction
  function automatic int divv(int i);
    case (i) 0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 8; endcase
  endfunction
  function automatic int cnt_of(int i);
    return int'((HZ * 64'd7800) / (64'd64 * longint'(divv(i)) * 64'd1_000_000_000));
  endfunction

  task automatic check(bit ok, string tag, int act, int expv, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push(int k, int v, int g, string tag);
    ev_t e;
    e.kind = k; e.val = v; e.min_gap = g; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: every port-visible register change is popped against the scoreboard.
  task automatic observe(int k, int v);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(0, "R12", v, -1, $sformatf("unexpected change of kind %0d", k));
    end else begin
      e = exp_q.pop_front();
      check(e.kind == k && e.val == v, e.tag, k * 1000 + v, e.kind * 1000 + e.val,
            "write order/value (kind*1000+value)");
      check(cyc - last_ev >= e.min_gap, (e.min_gap > PLL) ? "R9" : "R8",
            cyc - last_ev, e.min_gap, "cycles since previous write");
    end
    last_ev = cyc;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (mem_ctrl[16] != p_sr)      observe(0, int'(mem_ctrl[16]));
      if (div_sel != p_div)          observe(1, int'(div_sel));
      if (mem_ctrl[14:8] != p_cnt)   observe(2, int'(mem_ctrl[14:8]));
      if ((mem_ctrl & 17'h08000) != 0 || mem_ctrl[7:0] != 0)
        check(0, "R3", int'(mem_ctrl), 0, "unused control bits");
    end
    p_sr = mem_ctrl[16]; p_div = div_sel; p_cnt = mem_ctrl[14:8];
  end

  task automatic leg(int f, int t);
    int g;
    g = prev_div ? PLL : 0;
    if (f == 1 && t == 0) begin
      push(0, 0, g, "R4"); push(1, code_of(0), 0, "R4"); push(2, cnt_of(0), PLL, "R3");
      prev_div = 0;
    end else if (f == 0 && t == 1) begin
      push(2, cnt_of(1), g, "R5");
      push(1, code_of(1), 64 * (cnt_of(0) + cnt_of(1)) * divv(0), "R5");
      push(0, 1, PLL, "R5");
      prev_div = 0;
    end else if (f < t) begin
      push(2, cnt_of(t), g, "R7"); push(1, code_of(t), 0, "R7");
      prev_div = 1;
    end else begin
      push(1, code_of(t), g, "R7"); push(2, cnt_of(t), PLL, "R3");
      prev_div = 0;
    end
  endtask

  task automatic request(int idx, bit inject);
    bit got;
    got = 0;
    @(negedge clk);
    req_valid = 1'b1; req_idx = 3'(idx);
    @(negedge clk);
    req_valid = 1'b0;
    if (idx > 4) begin
      check(req_err == 1 && req_ack == 0 && busy == 0, "R11",
            {req_err, req_ack, busy}, 3'b100, "err/ack/busy");
      repeat (30) @(negedge clk);
    end else if (idx == cur) begin
      check(req_ack == 1 && busy == 0, "R10", {req_ack, busy}, 2'b10, "ack/busy");
      repeat (30) @(negedge clk);
    end else begin
      check(busy == 1, "R12", busy, 1, "busy during sequence");
      for (int k = 0; k < 40000; k++) begin
        if (req_ack) begin got = 1; break; end
        if (inject && k == 30) begin req_valid = 1'b1; req_idx = 3'd2; end
        else req_valid = 1'b0;
        @(negedge clk);
      end
      req_valid = 1'b0;
      check(got, "R12", got, 1, "acknowledge seen");
      @(negedge clk);
      check(req_ack == 0 && busy == 0, "R12", {req_ack, busy}, 0, "one-cycle ack, idle");
      repeat (40) @(negedge clk);
      check(req_ack == 0, "R12", req_ack, 0, "no second ack");
      cur = idx;
    end
    check(exp_q.size() == 0, "R6", exp_q.size(), 0, "expected writes left over");
    check(int'(div_sel) == code_of(cur), "R2", div_sel, code_of(cur), "final divisor code");
    check(int'(mem_ctrl[14:8]) == cnt_of(cur), "R3", mem_ctrl[14:8], cnt_of(cur), "final count");
  endtask

  task automatic move(int idx, bit inject);
    int hop;
    prev_div = 0;
    if (idx <= 4 && idx != cur) begin
      hop = ((cur == 0 && idx > 1) || (cur > 1 && idx == 0)) ? 1 : idx;
      leg(cur, hop);
      if (hop != idx) leg(hop, idx);
    end
    request(idx, inject);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(div_sel == 3'b000 && mem_ctrl[16] == 0, "R1", {div_sel, mem_ctrl[16]}, 0, "reset div/sr");
    check(int'(mem_ctrl[14:8]) == cnt_of(0), "R1", mem_ctrl[14:8], cnt_of(0), "reset count");
    check(!busy && !req_ack && !req_err, "R1", {busy, req_ack, req_err}, 0, "reset status");
    rst_n = 1'b1;
    @(negedge clk);
    last_ev = cyc; mon_on = 1;
    move(0, 0);   // R10 same target
    move(7, 0);   // R11 illegal index
    move(1, 0);   // R5, R9
    move(0, 0);   // R4
    move(4, 1);   // R6 via /2, R12 request during busy ignored
    move(5, 0);   // R11
    move(2, 0);   // R7 decrease
    move(3, 0);   // R7 increase
    move(3, 0);   // R10
    move(0, 0);   // R6 down through /2
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule